// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Masking Unit

This unit gathers the three interrupt events of a serial peripheral controller (a frame sequence that has finished transmitting, received data that is ready, and a receive overrun) into a sticky raw status. A per-event enable taken from the controller's control word gates each raw bit into a masked status, and a single level interrupt line is raised whenever any masked bit is set.

Software reaches the unit through a plain word-addressed register port: a one-cycle access strobe with a write flag, an address and write data, and read data returned in the following cycle. There is no back-pressure: every strobed access completes in one cycle. Raw bits are cleared by writing ones to a clear register. The status, raw and masked registers are read-only. Event inputs are single-cycle pulses from the frame sequencer and the FIFOs.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the control word, raw status and masked status are all zero, the interrupt line is low and the read data is zero.
- R2: An input pulse sets its raw bit on the next clock edge and the bit stays set until cleared; the done pulse sets bit 0, the receive-ready pulse bit 1 and the overrun pulse bit 2 of the raw register (word address 2).
- R3: Masked bit 0 is raw bit 0 AND control bit 5, masked bit 1 is raw bit 1 AND control bit 4, masked bit 2 is raw bit 2 AND control bit 6; the masked register is at word address 3 and its bits above 2 read zero, as do the raw register's.
- R4: Writing the clear register (word address 4) clears every raw bit whose write-data bit at the same position is 1; bits written with 0 keep their value.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the raw bit ends set.
- R6: Writes to the status (word address 1), raw and masked registers change neither the raw status nor the control word.
- R7: The interrupt line is a register: it is high in the cycle after any masked bit is set and low in the cycle after none is.
- R8: The control word (word address 0) reads back every bit as written; the status register returns the status input; the clear register and unused addresses read zero.
- R9: Read data appears on the read-data output in the cycle after a read strobe and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_done_i | input | 1 | Pulse: transfer sequence done |
| ev_rxrdy_i | input | 1 | Pulse: receive data ready |
| ev_ovf_i | input | 1 | Pulse: receive overrun |
| stat_i | input | DW | Controller status word shown at the status address |
| acc_en_i | input | 1 | Register access strobe |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | AW | Word address |
| acc_wdata_i | input | DW | Write data |
| acc_rdata_o | output | DW | Read data, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach from the ports is an event pulse landing in exactly the cycle that a clear write names the same bit, since the write and the event come from unrelated sources. The bench drives both on the same falling edge so that they meet at one rising edge, then reads the raw register to confirm the bit survived. Interrupt timing is checked one edge at a time after an event to pin the single-cycle lag of the line.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned NUM_EV   = 3;
  localparam int unsigned EV_DONE  = 0;
  localparam int unsigned EV_RXRDY = 1;
  localparam int unsigned EV_OVF   = 2;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_STAT = 1;
  localparam int unsigned ADR_RAW  = 2;
  localparam int unsigned ADR_MASK = 3;
  localparam int unsigned ADR_CLR  = 4;

  // control-word bit that enables each event
  function automatic int unsigned en_bit(input int unsigned ev);
    case (ev)
      EV_DONE:  return 5;
      EV_RXRDY: return 4;
      default:  return 6;
    endcase
  endfunction
endpackage

// File: rtl/spi_irq_raw.sv
module spi_irq_raw #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] raw_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // event takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n)        raw_q[g] <= 1'b0;
      else if (ev_i[g])  raw_q[g] <= 1'b1;
      else if (clr_i[g]) raw_q[g] <= 1'b0;
    end

    // R2, R5
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[g] |=> raw_q[g]);
    // R4
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !ev_i[g]) |=> !raw_q[g]);
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[g] && !ev_i[g]) |=> $stable(raw_q[g]));
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_irq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned N  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  raw_i,
  input  logic [DW-1:0] ctrl_i,
  output logic [N-1:0]  masked_o,
  output logic          irq_o
);
  logic [N-1:0] en;
  logic         irq_q;

  for (genvar g = 0; g < N; g++) begin : g_en
    assign en[g] = ctrl_i[en_bit(g)];
  end

  assign masked_o = raw_i & en;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |masked_o;
  end

  assign irq_o = irq_q;

  // R7
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|masked_o) |=> irq_o);
  a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|masked_o) |=> !irq_o);
  // R3
  a_r3_mask_in_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_o & ~raw_i) == '0);
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 3,
  parameter int unsigned N  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en_i,
  input  logic          acc_wr_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_wdata_i,
  input  logic [DW-1:0] stat_i,
  input  logic [N-1:0]  raw_i,
  input  logic [N-1:0]  masked_i,
  output logic [DW-1:0] ctrl_o,
  output logic [N-1:0]  clr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned PAD = DW - N;

  logic          wr_s, rd_s;
  logic [DW-1:0] ctrl_q, rdata_q, rd_mux;

  assign wr_s = acc_en_i &&  acc_wr_i;
  assign rd_s = acc_en_i && !acc_wr_i;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_s && acc_addr_i == AW'(ADR_CTRL))
      ctrl_q <= acc_wdata_i;
  end

  assign clr_o = (wr_s && acc_addr_i == AW'(ADR_CLR)) ? acc_wdata_i[N-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (acc_addr_i == AW'(ADR_CTRL))      rd_mux = ctrl_q;
    else if (acc_addr_i == AW'(ADR_STAT)) rd_mux = stat_i;
    else if (acc_addr_i == AW'(ADR_RAW))  rd_mux = {{PAD{1'b0}}, raw_i};
    else if (acc_addr_i == AW'(ADR_MASK)) rd_mux = {{PAD{1'b0}}, masked_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_s) rdata_q <= rd_mux;
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rdata_q;

  // R6
  a_r6_ro_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && acc_addr_i != AW'(ADR_CTRL)) |=> $stable(ctrl_q));
  // R9
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_s |=> $stable(rdata_q));
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_done_i,
  input  logic          ev_rxrdy_i,
  input  logic          ev_ovf_i,
  input  logic [DW-1:0] stat_i,
  input  logic          acc_en_i,
  input  logic          acc_wr_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [DW-1:0] acc_wdata_i,
  output logic [DW-1:0] acc_rdata_o,
  output logic          irq_o
);
  localparam int unsigned N = NUM_EV;

  logic [N-1:0]  ev, clr, raw, masked;
  logic [DW-1:0] ctrl;

  always_comb begin
    ev           = '0;
    ev[EV_DONE]  = ev_done_i;
    ev[EV_RXRDY] = ev_rxrdy_i;
    ev[EV_OVF]   = ev_ovf_i;
  end

  spi_irq_regs #(.DW(DW), .AW(AW), .N(N)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_en_i(acc_en_i), .acc_wr_i(acc_wr_i), .acc_addr_i(acc_addr_i),
    .acc_wdata_i(acc_wdata_i), .stat_i(stat_i), .raw_i(raw),
    .masked_i(masked), .ctrl_o(ctrl), .clr_o(clr), .rdata_o(acc_rdata_o)
  );

  spi_irq_raw #(.N(N)) u_raw (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .clr_i(clr), .raw_o(raw)
  );

  spi_irq_mask #(.DW(DW), .N(N)) u_mask (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .ctrl_i(ctrl),
    .masked_o(masked), .irq_o(irq_o)
  );
endmodule

// File: tb/spi_irq_ctrl_test.sv
`timescale 1ns/1ps
module spi_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_done = 0, ev_rxrdy = 0, ev_ovf = 0;
  logic [31:0] stat = 32'h0;
  logic        en = 0, wr = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  spi_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ev_done_i(ev_done), .ev_rxrdy_i(ev_rxrdy),
    .ev_ovf_i(ev_ovf), .stat_i(stat), .acc_en_i(en), .acc_wr_i(wr),
    .acc_addr_i(addr), .acc_wdata_i(wdata), .acc_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    en = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    en = 0; wr = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    en = 1; wr = 0; addr = a;
    @(negedge clk);
    en = 0;
    d = rdata;
  endtask

  task automatic pulse(input logic [2:0] e);
    {ev_ovf, ev_rxrdy, ev_done} = e;
    @(negedge clk);
    {ev_ovf, ev_rxrdy, ev_done} = 3'b0;
  endtask

  function automatic logic [2:0] exp_mask(input logic [2:0] r, input logic [31:0] c);
    return {r[2] & c[6], r[1] & c[4], r[0] & c[5]};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rdata", rdata, 0);
    reg_rd(0, d); check("R1 ctrl", d, 0);
    reg_rd(2, d); check("R1 raw", d, 0);
    reg_rd(3, d); check("R1 masked", d, 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    pulse(3'b001); reg_rd(2, d); check("R2 done bit0", d, 32'h1);
    pulse(3'b010); reg_rd(2, d); check("R2 rxrdy bit1", d, 32'h3);
    repeat (3) @(negedge clk);
    pulse(3'b100); reg_rd(2, d); check("R2 ovf bit2 sticky", d, 32'h7);
    reg_wr(4, 32'h7); reg_rd(2, d); check("R4 clear all", d, 0);
  endtask

  task automatic t_mask_map;
    logic [31:0] d;
    logic [31:0] c;
    pulse(3'b111);
    for (int k = 0; k < 8; k++) begin
      c = {25'b0, k[2:0], 4'b0};
      reg_wr(0, c);
      reg_rd(3, d);
      check("R3 masked map", d, {29'b0, exp_mask(3'b111, c)});
    end
    reg_wr(0, 32'h0000_0070);
    reg_wr(4, 32'h5); reg_rd(3, d); check("R3 masked partial", d, 32'h2);
    reg_wr(4, 32'h7); reg_wr(0, 0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    pulse(3'b111);
    reg_wr(4, 32'hFFFF_FFF8); reg_rd(2, d); check("R4 zeros keep", d, 32'h7);
    reg_wr(4, 32'h2); reg_rd(2, d); check("R4 clear bit1", d, 32'h5);
    reg_wr(4, 32'h5); reg_rd(2, d); check("R4 clear rest", d, 0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    ev_rxrdy = 1;
    reg_wr(4, 32'h2);
    ev_rxrdy = 0;
    reg_rd(2, d); check("R5 event wins", d, 32'h2);
    pulse(3'b001);
    ev_ovf = 1;
    reg_wr(4, 32'h7);
    ev_ovf = 0;
    reg_rd(2, d); check("R5 other bits cleared", d, 32'h4);
    reg_wr(4, 32'h7);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    reg_wr(0, 32'h0000_0070);
    pulse(3'b111);
    reg_wr(2, 32'h0); reg_wr(3, 32'hFFFF_FFFF); reg_wr(1, 32'h0);
    reg_rd(2, d); check("R6 raw unchanged", d, 32'h7);
    reg_rd(0, d); check("R6 ctrl unchanged", d, 32'h70);
    reg_wr(4, 32'h7); reg_wr(0, 0);
  endtask

  task automatic t_irq;
    reg_wr(0, 32'h0000_0020);
    @(negedge clk);
    check("R7 idle low", {31'b0, irq}, 0);
    pulse(3'b010);
    @(negedge clk);
    check("R7 masked off low", {31'b0, irq}, 0);
    pulse(3'b001);
    check("R7 lag one cycle", {31'b0, irq}, 0);
    @(negedge clk);
    check("R7 high", {31'b0, irq}, 1);
    reg_wr(0, 32'h0000_0010);
    check("R7 still high (rxrdy)", {31'b0, irq}, 1);
    reg_wr(4, 32'h2);
    check("R7 lag on clear", {31'b0, irq}, 1);
    @(negedge clk);
    check("R7 low after clear", {31'b0, irq}, 0);
    reg_wr(4, 32'h7); reg_wr(0, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    reg_wr(0, 32'hA5C3_0F81); reg_rd(0, d); check("R8 ctrl readback", d, 32'hA5C3_0F81);
    stat = 32'h1234_5678; reg_rd(1, d); check("R8 status", d, 32'h1234_5678);
    pulse(3'b111);
    reg_rd(4, d); check("R8 clear reads 0", d, 0);
    reg_rd(6, d); check("R8 unused reads 0", d, 0);
    reg_rd(0, d);
    repeat (4) @(negedge clk);
    check("R9 rdata holds", rdata, 32'hA5C3_0F81);
    reg_wr(2, 32'h0);
    check("R9 write leaves rdata", rdata, 32'hA5C3_0F81);
    reg_wr(4, 32'h7); reg_wr(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_events; t_mask_map; t_clear; t_collision;
    t_readonly; t_irq; t_readback;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule